// File: doc/BRIEF.md
# Conditional Branch Resolver

The resolver decides the outcome of one conditional branch per clock. It takes the program counter of the branch, a decoded branch class, a four-bit condition code, a four-bit constant or bit-number field, an offset field and two register operands. From these it works out whether the branch is taken and which address executes next. The result is registered, so it appears one clock after the inputs.

Five branch classes are handled. The first compares one register against zero. Two classes compare a register against a constant picked from a small fixed table, one with a signed compare and one with an unsigned compare. A register group covers register-register compares, mask tests and single-bit tests. The last class is a short zero-test used by two-byte instructions. The top of the condition code inverts the register-group tests, so each test also has a negated form. Class and condition encodings with no meaning raise an illegal flag, and the branch is then reported as not taken.

Top module: `branch_resolve_unit`

## Requirements
- R1: When a three-byte branch (class 0 to 3) or an illegal encoding is not taken, next_pc equals pc + 3.
- R2: Class 0 (ZERO) tests operand a against zero. cond[1:0] selects the test: 0 is equal, 1 is not equal, 2 is signed less-than, 3 is signed greater-or-equal. When taken, the target is pc + 4 + off sign-extended from 12 bits.
- R3: Class 1 (SIMM) uses the same cond[1:0] tests against a signed constant indexed by idx. Indices 0 to 15 map to -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256. The taken target is pc + 4 + off[7:0] sign-extended. Bits off[11:8] have no effect.
- R4: Class 2 (UIMM) compares a against an unsigned table. This table equals the signed one except that index 0 gives 32768 and index 1 gives 65536. cond[1:0] = 2 tests a < k and cond[1:0] = 3 tests a >= k, both unsigned. The target is as in R3.
- R5: Class 3 (REG) with cond[2:0] = 0 takes the branch when (a AND b) is zero. With cond[2:0] = 4 it takes the branch when (a AND b) equals b. Setting cond[3] inverts either outcome.
- R6: Class 3 with cond[2:0] = 1, 2 or 3 tests a == b, signed a < b or unsigned a < b. Setting cond[3] turns these into !=, signed >= and unsigned >=.
- R7: Class 3 with cond[2:0] = 5 takes the branch when bit (b AND 31) of a is clear. With cond[2:0] = 6 or 7 it tests bit {cond[0], idx} of a. Setting cond[3] makes each of these a bit-set test.
- R8: Class 4 (SHORT) takes the branch on a == 0 when cond[0] = 0 and on a != 0 when cond[0] = 1. The taken target is pc + 4 + off[5:0] zero-extended. When not taken, next_pc is pc + 2.
- R9: Classes 5 to 7, and class 2 with cond[1:0] of 0 or 1, raise illegal and report not-taken.
- R10: Outputs change one clock after their inputs. An active-low reset clears taken, illegal and next_pc to zero.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the branch instruction |
| kind_i | input | 3 | Branch class (0 ZERO, 1 SIMM, 2 UIMM, 3 REG, 4 SHORT) |
| cond_i | input | 4 | Condition code |
| idx_i | input | 4 | Constant-table index or low bits of the bit number |
| off_i | input | 12 | Raw branch offset field |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Encoding not valid |
| next_pc_o | output | 32 | Address of the next instruction |

## Verification
Operands are chosen to sit on each side of every compare boundary. The same bit pattern, such as all-ones against 1, is run through both signed and unsigned compares, so a swapped signedness gives the wrong answer in one of them. Mask and bit tests use operands where (a AND b) being zero and (a AND b) equalling b disagree, and the bit-number tests place the only set or clear bit at positions 0, 8 and 31. The offset fields carry set upper bits that the narrower forms must ignore, so a wrong extension width moves the target. A wrapping address at the top of memory and the two table entries that differ between the signed and unsigned tables are also covered.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int TAB_IDX_W   = 4;
    localparam int TAB_ENTRIES = 1 << TAB_IDX_W;
    localparam int CONST_W     = 32;

    typedef enum logic [2:0] {
        BK_ZERO  = 3'd0,
        BK_SIMM  = 3'd1,
        BK_UIMM  = 3'd2,
        BK_REG   = 3'd3,
        BK_SHORT = 3'd4
    } br_kind_e;

    // register-group base tests, selected by cond[2:0]
    typedef enum logic [2:0] {
        RG_NONE   = 3'd0,
        RG_EQ     = 3'd1,
        RG_LT     = 3'd2,
        RG_LTU    = 3'd3,
        RG_ALL    = 3'd4,
        RG_BITREG = 3'd5,
        RG_BITLO  = 3'd6,
        RG_BITHI  = 3'd7
    } reg_test_e;

    // entry of the compare-constant tables; the unsigned variant
    // replaces only the first two entries
    function automatic logic [CONST_W-1:0] table_value(input int i, input bit uns);
        logic [CONST_W-1:0] v;
        if (uns && i == 0)       v = 32'd32768;
        else if (uns && i == 1)  v = 32'd65536;
        else if (i == 0)         v = '1;
        else if (i <= 8)         v = CONST_W'(i);
        else if (i == 9)         v = 32'd10;
        else if (i == 10)        v = 32'd12;
        else if (i == 11)        v = 32'd16;
        else                     v = 32'd32 << (i - 12);
        return v;
    endfunction

endpackage

// File: rtl/bru_const_table.sv
module bru_const_table #(
    parameter int XLEN         = 32,
    parameter bit UNSIGNED_TAB = 1'b0
) (
    input  logic [bru_pkg::TAB_IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]               value_o
);
    import bru_pkg::*;

    logic [XLEN-1:0] entries [TAB_ENTRIES];

    for (genvar g = 0; g < TAB_ENTRIES; g++) begin : g_entry
        if (UNSIGNED_TAB) begin : g_uns
            assign entries[g] = XLEN'(table_value(g, 1'b1));
        end else begin : g_sgn
            assign entries[g] = XLEN'($signed(table_value(g, 1'b0)));
        end
    end

    assign value_o = entries[idx_i];

endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [2:0]                    kind_i,
    input  logic [3:0]                    cond_i,
    input  logic [bru_pkg::TAB_IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]               a_i,
    input  logic [XLEN-1:0]               b_i,
    input  logic [XLEN-1:0]               simm_i,
    input  logic [XLEN-1:0]               uimm_i,
    output logic                          hit_o,
    output logic                          illegal_o
);
    import bru_pkg::*;

    localparam int BIT_W = $clog2(XLEN);

    logic            a_zero;
    logic            a_neg;
    logic [XLEN-1:0] a_and_b;
    logic [BIT_W-1:0] reg_bit;
    logic [BIT_W-1:0] imm_bit;
    logic            reg_base;
    logic            zero_hit;
    logic            simm_hit;

    always_comb begin
        a_zero  = (a_i == '0);
        a_neg   = a_i[XLEN-1];
        a_and_b = a_i & b_i;
        reg_bit = b_i[BIT_W-1:0];
        imm_bit = BIT_W'({cond_i[0], idx_i});

        case (cond_i[1:0])
            2'd0:    zero_hit = a_zero;
            2'd1:    zero_hit = !a_zero;
            2'd2:    zero_hit = a_neg;
            default: zero_hit = !a_neg;
        endcase

        case (cond_i[1:0])
            2'd0:    simm_hit = (a_i == simm_i);
            2'd1:    simm_hit = (a_i != simm_i);
            2'd2:    simm_hit = ($signed(a_i) < $signed(simm_i));
            default: simm_hit = ($signed(a_i) >= $signed(simm_i));
        endcase

        case (reg_test_e'(cond_i[2:0]))
            RG_NONE:   reg_base = (a_and_b == '0);
            RG_EQ:     reg_base = (a_i == b_i);
            RG_LT:     reg_base = ($signed(a_i) < $signed(b_i));
            RG_LTU:    reg_base = (a_i < b_i);
            RG_ALL:    reg_base = (a_and_b == b_i);
            RG_BITREG: reg_base = !a_i[reg_bit];
            default:   reg_base = !a_i[imm_bit];
        endcase

        hit_o     = 1'b0;
        illegal_o = 1'b0;
        case (kind_i)
            BK_ZERO:  hit_o = zero_hit;
            BK_SIMM:  hit_o = simm_hit;
            BK_UIMM: begin
                if (cond_i[1:0] == 2'd2)      hit_o = (a_i < uimm_i);
                else if (cond_i[1:0] == 2'd3) hit_o = (a_i >= uimm_i);
                else                          illegal_o = 1'b1;
            end
            BK_REG:   hit_o = reg_base ^ cond_i[3];
            BK_SHORT: hit_o = a_zero ^ cond_i[0];
            default:  illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN      = 32,
    parameter int LONG_W    = 12,
    parameter int MID_W     = 8,
    parameter int SHORT_W   = 6
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [2:0]        kind_i,
    input  logic [LONG_W-1:0] off_i,
    input  logic              taken_i,
    output logic [XLEN-1:0]   next_pc_o
);
    import bru_pkg::*;

    localparam logic [XLEN-1:0] TAKEN_BIAS = XLEN'(4);
    localparam logic [XLEN-1:0] SEQ_WIDE   = XLEN'(3);
    localparam logic [XLEN-1:0] SEQ_NARROW = XLEN'(2);

    logic [XLEN-1:0] off_ext;
    logic            is_short;

    always_comb begin
        is_short = (kind_i == BK_SHORT);
        case (kind_i)
            BK_ZERO:  off_ext = XLEN'($signed(off_i));
            BK_SHORT: off_ext = XLEN'(off_i[SHORT_W-1:0]);
            default:  off_ext = XLEN'($signed(off_i[MID_W-1:0]));
        endcase
        if (taken_i)       next_pc_o = pc_i + TAKEN_BIAS + off_ext;
        else if (is_short) next_pc_o = pc_i + SEQ_NARROW;
        else               next_pc_o = pc_i + SEQ_WIDE;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
    parameter int XLEN    = 32,
    parameter int LONG_W  = 12,
    parameter int MID_W   = 8,
    parameter int SHORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [2:0]        kind_i,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        idx_i,
    input  logic [LONG_W-1:0] off_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [XLEN-1:0]   next_pc_o
);
    typedef struct packed {
        logic            taken;
        logic            illegal;
        logic [XLEN-1:0] next_pc;
    } res_t;

    res_t res_d, res_q;

    logic [XLEN-1:0] simm_k;
    logic [XLEN-1:0] uimm_k;
    logic            hit;
    logic            bad_enc;
    logic [XLEN-1:0] target;

    bru_const_table #(.XLEN(XLEN), .UNSIGNED_TAB(1'b0)) u_stab (
        .idx_i  (idx_i),
        .value_o(simm_k)
    );

    bru_const_table #(.XLEN(XLEN), .UNSIGNED_TAB(1'b1)) u_utab (
        .idx_i  (idx_i),
        .value_o(uimm_k)
    );

    bru_cond_eval #(.XLEN(XLEN)) u_eval (
        .kind_i   (kind_i),
        .cond_i   (cond_i),
        .idx_i    (idx_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .simm_i   (simm_k),
        .uimm_i   (uimm_k),
        .hit_o    (hit),
        .illegal_o(bad_enc)
    );

    bru_target #(.XLEN(XLEN), .LONG_W(LONG_W), .MID_W(MID_W), .SHORT_W(SHORT_W)) u_tgt (
        .pc_i     (pc_i),
        .kind_i   (kind_i),
        .off_i    (off_i),
        .taken_i  (hit && !bad_enc),
        .next_pc_o(target)
    );

    always_comb begin
        res_d         = res_q;
        res_d.taken   = hit && !bad_enc;
        res_d.illegal = bad_enc;
        res_d.next_pc = target;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign taken_o   = res_q.taken;
    assign illegal_o = res_q.illegal;
    assign next_pc_o = res_q.next_pc;

endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk #(
    parameter int XLEN   = 32,
    parameter int LONG_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_i,
    input logic [2:0]        kind_i,
    input logic [LONG_W-1:0] off_i,
    input logic              taken_o,
    input logic              illegal_o,
    input logic [XLEN-1:0]   next_pc_o
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !taken_o); // R9

    AST_BAD_KIND_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(kind_i) > 3'd4) |-> illegal_o); // R9

    AST_WIDE_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !taken_o && $past(kind_i) != 3'd4) |-> (next_pc_o == $past(pc_i) + 32'd3)); // R1

    AST_SHORT_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !taken_o && $past(kind_i) == 3'd4) |-> (next_pc_o == $past(pc_i) + 32'd2)); // R8

    AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && taken_o && $past(kind_i) == 3'd0)
        |-> (next_pc_o == $past(pc_i) + 32'd4 + XLEN'($signed($past(off_i))))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && !illegal_o && next_pc_o == '0)); // R10

endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.XLEN(XLEN), .LONG_W(LONG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_i     (pc_i),
    .kind_i   (kind_i),
    .off_i    (off_i),
    .taken_o  (taken_o),
    .illegal_o(illegal_o),
    .next_pc_o(next_pc_o)
);

// File: tb/sim_branch_resolve_unit.sv
module sim_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [2:0]  kind_i = '0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  idx_i = '0;
    logic [11:0] off_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        taken_o;
    logic        illegal_o;
    logic [31:0] next_pc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_resolve_unit u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i), .cond_i(cond_i),
        .idx_i(idx_i), .off_i(off_i), .a_i(a_i), .b_i(b_i),
        .taken_o(taken_o), .illegal_o(illegal_o), .next_pc_o(next_pc_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] pc;
        logic [2:0]  kind;
        logic [3:0]  cond;
        logic [3:0]  idx;
        logic [11:0] off;
        logic [31:0] a;
        logic [31:0] b;
        logic        e_taken;
        logic        e_ill;
        logic [31:0] e_npc;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  32'h1000, 3'd0, 4'h0, 4'h0, 12'h010, 32'h0,        32'h0,  1'b1, 1'b0, 32'h1014}, // R2 eqz
        '{8'd1,  32'h1000, 3'd0, 4'h0, 4'h0, 12'h010, 32'h5,        32'h0,  1'b0, 1'b0, 32'h1003}, // R1
        '{8'd2,  32'h1000, 3'd0, 4'h2, 4'h0, 12'hFFC, 32'h80000000, 32'h0,  1'b1, 1'b0, 32'h1000}, // R2 ltz, back
        '{8'd2,  32'h1000, 3'd0, 4'h3, 4'h0, 12'h000, 32'hFFFFFFFF, 32'h0,  1'b0, 1'b0, 32'h1003}, // R2 gez
        '{8'd3,  32'h1000, 3'd1, 4'h0, 4'h0, 12'hF20, 32'hFFFFFFFF, 32'h0,  1'b1, 1'b0, 32'h1024}, // R3 entry -1
        '{8'd3,  32'h1000, 3'd1, 4'h2, 4'hB, 12'h080, 32'd15,       32'h0,  1'b1, 1'b0, 32'h0F84}, // R3 lt 16
        '{8'd3,  32'h1000, 3'd1, 4'h3, 4'hF, 12'h004, 32'd255,      32'h0,  1'b0, 1'b0, 32'h1003}, // R3 ge 256
        '{8'd3,  32'h1000, 3'd1, 4'h1, 4'h9, 12'h004, 32'd10,       32'h0,  1'b0, 1'b0, 32'h1003}, // R3 ne 10
        '{8'd4,  32'h1000, 3'd2, 4'h2, 4'h0, 12'h008, 32'h7FFF,     32'h0,  1'b1, 1'b0, 32'h100C}, // R4 ltu 32768
        '{8'd4,  32'h1000, 3'd2, 4'h3, 4'h1, 12'h000, 32'hFFFFFFFF, 32'h0,  1'b1, 1'b0, 32'h1004}, // R4 geu 65536
        '{8'd4,  32'h1000, 3'd2, 4'h3, 4'h2, 12'h000, 32'd1,        32'h0,  1'b0, 1'b0, 32'h1003}, // R4 geu 2
        '{8'd9,  32'h1000, 3'd2, 4'h0, 4'h0, 12'h004, 32'h0,        32'h0,  1'b0, 1'b1, 32'h1003}, // R9 uimm cond 0
        '{8'd5,  32'h1000, 3'd3, 4'h0, 4'h0, 12'h004, 32'hF0,       32'h0F, 1'b1, 1'b0, 32'h1008}, // R5 none
        '{8'd5,  32'h1000, 3'd3, 4'h8, 4'h0, 12'h004, 32'hF0,       32'h0F, 1'b0, 1'b0, 32'h1003}, // R5 any
        '{8'd5,  32'h1000, 3'd3, 4'h4, 4'h0, 12'h004, 32'hFF,       32'h0F, 1'b1, 1'b0, 32'h1008}, // R5 all
        '{8'd5,  32'h1000, 3'd3, 4'hC, 4'h0, 12'h004, 32'hFF,       32'h0F, 1'b0, 1'b0, 32'h1003}, // R5 not-all
        '{8'd6,  32'h1000, 3'd3, 4'h2, 4'h0, 12'h004, 32'hFFFFFFFF, 32'h1,  1'b1, 1'b0, 32'h1008}, // R6 lt
        '{8'd6,  32'h1000, 3'd3, 4'h3, 4'h0, 12'h004, 32'hFFFFFFFF, 32'h1,  1'b0, 1'b0, 32'h1003}, // R6 ltu
        '{8'd6,  32'h1000, 3'd3, 4'hB, 4'h0, 12'h004, 32'hFFFFFFFF, 32'h1,  1'b1, 1'b0, 32'h1008}, // R6 geu
        '{8'd6,  32'h1000, 3'd3, 4'h1, 4'h0, 12'h004, 32'd7,        32'd7,  1'b1, 1'b0, 32'h1008}, // R6 eq
        '{8'd7,  32'h1000, 3'd3, 4'hD, 4'h0, 12'h004, 32'h100,      32'h28, 1'b1, 1'b0, 32'h1008}, // R7 bit set via b
        '{8'd7,  32'h1000, 3'd3, 4'h5, 4'h0, 12'h004, 32'h100,      32'h28, 1'b0, 1'b0, 32'h1003}, // R7 bit clear via b
        '{8'd7,  32'h1000, 3'd3, 4'hF, 4'hF, 12'h004, 32'h80000000, 32'h0,  1'b1, 1'b0, 32'h1008}, // R7 imm bit 31
        '{8'd7,  32'h1000, 3'd3, 4'h6, 4'h0, 12'h004, 32'hFFFFFFFE, 32'h0,  1'b1, 1'b0, 32'h1008}, // R7 imm bit 0
        '{8'd8,  32'h1000, 3'd4, 4'h0, 4'h0, 12'hFFF, 32'h0,        32'h0,  1'b1, 1'b0, 32'h1043}, // R8 short eqz
        '{8'd8,  32'h1000, 3'd4, 4'h1, 4'h0, 12'h001, 32'h0,        32'h0,  1'b0, 1'b0, 32'h1002}, // R8 short nez
        '{8'd9,  32'h1000, 3'd5, 4'h0, 4'h0, 12'h004, 32'h0,        32'h0,  1'b0, 1'b1, 32'h1003}, // R9 bad class
        '{8'd11, 32'hFFFFFFFE, 3'd0, 4'h1, 4'h0, 12'h000, 32'h1,    32'h0,  1'b1, 1'b0, 32'h00000002} // R11 wrap
    };

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        pc_i = v.pc; kind_i = v.kind; cond_i = v.cond; idx_i = v.idx;
        off_i = v.off; a_i = v.a; b_i = v.b;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R10: reset state
        repeat (2) @(negedge clk);
        check("reset taken", 10, 32'(taken_o), 32'd0);
        check("reset illegal", 10, 32'(illegal_o), 32'd0);
        check("reset next_pc", 10, next_pc_o, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("vec %0d taken", i), int'(VECS[i].req), 32'(taken_o), 32'(VECS[i].e_taken));
            check($sformatf("vec %0d illegal", i), int'(VECS[i].req), 32'(illegal_o), 32'(VECS[i].e_ill));
            check($sformatf("vec %0d next_pc", i), int'(VECS[i].req), next_pc_o, VECS[i].e_npc);
        end

        // R10: one-cycle latency, output holds old value before the edge
        @(negedge clk);
        pc_i = 32'h2000; kind_i = 3'd0; cond_i = 4'h0; off_i = 12'h020; a_i = 32'h0;
        #1;
        check("latency before edge", 10, next_pc_o, 32'h00000002);
        @(negedge clk);
        check("latency after edge", 10, next_pc_o, 32'h2024);

        // R10: reset in the middle of activity clears outputs at once
        rst_n = 1'b0;
        #1;
        check("mid reset taken", 10, 32'(taken_o), 32'd0);
        check("mid reset next_pc", 10, next_pc_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("after reset release", 10, next_pc_o, 32'h2024);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule